// File: doc/BRIEF.md
# Serial-Addressed Octal Code Register Bank

This block is the digital front end of an eight-channel converter that is programmed over a three-wire serial link. A host sends 12-bit frames on a serial data pin, one bit per rising edge of a slow serial clock. Each frame holds a 4-bit channel address followed by an 8-bit code. A separate load strobe then commits the code to the holding register of the addressed channel. The eight held codes leave the block in parallel and drive the converters.

An active-low preset pin asynchronously returns every channel to midscale (0x80) and empties the shift register. The last stage of the shift register is brought out as a serial output, so several blocks can be chained or a frame can be read back. The serial pins, load and preset are sampled with a fast system clock through two-flop synchronizers and edge-detected. A sticky flag reports a serial clock edge that arrives while the load strobe is high. A synchronous input clears the flag.

Top module: `serial_octal_bank`

## Requirements
- R1: Each rising edge of the serial clock shifts the serial data bit into stage 0 of a 12-stage shift register, and every other stage moves up by one.
- R2: A frame is 12 bits. The first four bits are the channel address, most significant bit first. The last eight bits are the code, most significant bit first. After 12 shifts the address sits in stages 11..8 and the code in stages 7..0.
- R3: Address value k in 1..8 selects channel k-1. The channel c code appears on code_o[8c+7:8c].
- R4: Address values 0 and 9 through 15 are no-ops. A load that decodes one of them changes no channel code.
- R5: A rising edge of the load strobe copies the 8 code bits of the shift register into the decoded channel and leaves every other channel unchanged.
- R6: ser_dout_o carries stage 11, so a bit shifted in at serial edge n appears there after edge n+11.
- R7: While preset is low, all eight codes read 0x80 and the shift register holds all zeros. Serial clock and load edges have no effect during that time.
- R8: If the load strobe is still high when preset is released, the release counts as a load edge. The shift register is zero at that point, so the load decodes as a no-op and all channels stay at 0x80.
- R9: A serial clock rising edge seen while the load strobe is high sets proto_err_o. The flag stays set, and the bit is still shifted in.
- R10: A high err_clr_i at a system clock edge clears proto_err_o. A new violation in the same cycle wins over the clear.
- R11: A load leaves the shift register contents unchanged.
- R12: After rst_n is asserted, every code is 0x80, the shift register is zero, ser_dout_o is 0 and proto_err_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock pin; its rising edge shifts in a bit |
| ser_din_i | input | 1 | Serial data pin |
| load_i | input | 1 | Load strobe pin; its rising edge commits a code |
| preset_n_i | input | 1 | Asynchronous active-low midscale preset |
| err_clr_i | input | 1 | Synchronous clear of the protocol-error flag |
| ser_dout_o | output | 1 | Last shift-register stage, for chaining or readback |
| code_o | output | 64 | Eight channel codes; channel c at bits 8c+7:8c |
| proto_err_o | output | 1 | Sticky flag for a serial edge while load is high |

## Verification
The bench builds the block with its default parameters: eight channels, 8-bit codes, a 4-bit address and two synchronizer stages. With sixteen address values and only eight channels, random frames hit the no-op codes both below and above the channel range about as often as the valid ones. Because the synchronizers are only two stages deep, slow pin toggles of a few system clocks each are enough to test preset-release races and serial edges that arrive while load is held high.

// File: rtl/osb_pkg.sv
package osb_pkg;

  // Address decode: returns 1 when the address selects channel idx.
  function automatic logic addr_hits(input logic [7:0] addr, input int idx);
    return (int'(addr) == idx + 1);
  endfunction

  // Midscale code for a given code width.
  function automatic logic [31:0] midscale(input int width);
    return 32'd1 << (width - 1);
  endfunction

endpackage

// File: rtl/osb_sync.sv
module osb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/osb_shifter.sv
module osb_shifter #(
  parameter int FRAME_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               preset_n_i,
  input  logic               shift_en_i,
  input  logic               din_i,
  output logic [FRAME_W-1:0] frame_o
);
  logic [FRAME_W-1:0] frame_q;
  logic [FRAME_W-1:0] frame_d;

  always_comb begin
    frame_d = frame_q;
    if (shift_en_i) begin
      frame_d = {frame_q[FRAME_W-2:0], din_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n or negedge preset_n_i) begin
    if (!rst_n || !preset_n_i) begin
      frame_q <= '0;
    end else begin
      frame_q <= frame_d;
    end
  end

  assign frame_o = frame_q;

  // R1: a shift places the sampled input bit in stage 0
  p_shift_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en_i && preset_n_i) |=> (!preset_n_i || frame_q[0] == $past(din_i)));

  // R11: without a shift the register holds its contents
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en_i && preset_n_i) |=> (!preset_n_i || $stable(frame_q)));
endmodule

// File: rtl/osb_decoder.sv
module osb_decoder
  import osb_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int NCH    = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              load_ev_i,
  output logic [NCH-1:0]    wr_en_o
);
  logic [7:0] addr_ext;

  always_comb begin
    addr_ext = 8'(addr_i);
  end

  for (genvar c = 0; c < NCH; c++) begin : g_dec
    assign wr_en_o[c] = load_ev_i && addr_hits(addr_ext, c);
  end

  // R3: at most one channel is selected by any address
  always_comb begin
    a_onehot_r3: assert ($onehot0(wr_en_o));
  end
endmodule

// File: rtl/osb_chan_bank.sv
module osb_chan_bank
  import osb_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int CODE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  preset_n_i,
  input  logic [NCH-1:0]        wr_en_i,
  input  logic [CODE_W-1:0]     wr_data_i,
  output logic [NCH*CODE_W-1:0] code_o
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(midscale(CODE_W));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] code_d;

    always_comb begin
      code_d = code_q;
      if (wr_en_i[c]) begin
        code_d = wr_data_i;
      end
    end

    always_ff @(posedge clk or negedge rst_n or negedge preset_n_i) begin
      if (!rst_n || !preset_n_i) begin
        code_q <= MID;
      end else begin
        code_q <= code_d;
      end
    end

    assign code_o[c*CODE_W +: CODE_W] = code_q;

    // R7: preset holds the channel at midscale
    p_preset_mid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !preset_n_i |-> code_q == MID);

    // R5: a write lands the shift-register code in this channel
    p_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i[c] && preset_n_i) |=> (!preset_n_i || code_q == $past(wr_data_i)));
  end
endmodule

// File: rtl/serial_octal_bank.sv
module serial_octal_bank
  import osb_pkg::*;
#(
  parameter int NCH         = 8,
  parameter int CODE_W      = 8,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ser_clk_i,
  input  logic                  ser_din_i,
  input  logic                  load_i,
  input  logic                  preset_n_i,
  input  logic                  err_clr_i,
  output logic                  ser_dout_o,
  output logic [NCH*CODE_W-1:0] code_o,
  output logic                  proto_err_o
);
  localparam int FRAME_W = ADDR_W + CODE_W;

  logic sclk_s, din_s, load_s, preset_s;
  logic sclk_prev_q, sclk_prev_d;
  logic load_prev_q, load_prev_d;
  logic err_q, err_d;
  logic shift_ev, load_ev, viol_ev;
  logic [FRAME_W-1:0] frame;
  logic [NCH-1:0]     wr_en;

  osb_sync #(.STAGES(SYNC_STAGES)) u_sync_sclk (
    .clk(clk), .rst_n(rst_n), .d_i(ser_clk_i), .q_o(sclk_s));
  osb_sync #(.STAGES(SYNC_STAGES)) u_sync_din (
    .clk(clk), .rst_n(rst_n), .d_i(ser_din_i), .q_o(din_s));
  osb_sync #(.STAGES(SYNC_STAGES)) u_sync_load (
    .clk(clk), .rst_n(rst_n), .d_i(load_i), .q_o(load_s));
  osb_sync #(.STAGES(SYNC_STAGES)) u_sync_preset (
    .clk(clk), .rst_n(rst_n), .d_i(preset_n_i), .q_o(preset_s));

  // Edge detection, gated while the synchronized preset is still active
  always_comb begin
    shift_ev    = sclk_s && !sclk_prev_q && preset_s && preset_n_i;
    load_ev     = load_s && !load_prev_q && preset_s && preset_n_i;
    viol_ev     = shift_ev && load_s;
    sclk_prev_d = sclk_s;
    load_prev_d = preset_s ? load_s : 1'b0;
    err_d       = err_q;
    if (err_clr_i) begin
      err_d = 1'b0;
    end
    if (viol_ev) begin
      err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b0;
      load_prev_q <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      sclk_prev_q <= sclk_prev_d;
      load_prev_q <= load_prev_d;
      err_q       <= err_d;
    end
  end

  osb_shifter #(.FRAME_W(FRAME_W)) u_shifter (
    .clk        (clk),
    .rst_n      (rst_n),
    .preset_n_i (preset_n_i),
    .shift_en_i (shift_ev),
    .din_i      (din_s),
    .frame_o    (frame)
  );

  osb_decoder #(.ADDR_W(ADDR_W), .NCH(NCH)) u_decoder (
    .addr_i    (frame[FRAME_W-1 -: ADDR_W]),
    .load_ev_i (load_ev),
    .wr_en_o   (wr_en)
  );

  osb_chan_bank #(.NCH(NCH), .CODE_W(CODE_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .preset_n_i (preset_n_i),
    .wr_en_i    (wr_en),
    .wr_data_i  (frame[CODE_W-1:0]),
    .code_o     (code_o)
  );

  assign ser_dout_o  = frame[FRAME_W-1];
  assign proto_err_o = err_q;

  // R4: a load with no decoded channel leaves every code unchanged
  p_noop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ev && wr_en == '0 && preset_n_i) |=> (!preset_n_i || $stable(code_o)));

  // R9: a serial edge while load is high raises the flag
  p_viol_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    viol_ev |=> proto_err_o);

  // R10: the flag only drops on a clear request
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (proto_err_o && !err_clr_i) |=> proto_err_o);

  // R6: the cascade output follows the previous stage one shift later
  p_dout_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_ev && preset_n_i) |=> (!preset_n_i || ser_dout_o == $past(frame[FRAME_W-2])));
endmodule

// File: tb/serial_octal_bank_tb.sv
module serial_octal_bank_tb;
  localparam int NCH = 8;
  localparam int CW  = 8;

  logic clk = 1'b0;
  logic rst_n, ser_clk, ser_din, load, preset_n, err_clr;
  logic ser_dout, proto_err;
  logic [NCH*CW-1:0] code;

  logic [CW-1:0] exp_code [NCH];
  logic [11:0]   exp_sh;
  logic          exp_err;
  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  serial_octal_bank u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_din_i(ser_din),
    .load_i(load), .preset_n_i(preset_n), .err_clr_i(err_clr),
    .ser_dout_o(ser_dout), .code_o(code), .proto_err_o(proto_err));

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit addr_valid(input logic [3:0] a);
    return (a >= 4'd1 && a <= 4'd8);
  endfunction

  task automatic check_all(input string req);
    for (int c = 0; c < NCH; c++) chk(req, 32'(code[c*CW +: CW]), 32'(exp_code[c]));
    chk(req, 32'(ser_dout), 32'(exp_sh[11]));
    chk(req, 32'(proto_err), 32'(exp_err));
  endtask

  task automatic send_bit(input logic b);
    ser_din = b;
    wait_clk(4);
    ser_clk = 1'b1;
    wait_clk(4);
    ser_clk = 1'b0;
    wait_clk(4);
    exp_sh = {exp_sh[10:0], b};
    if (load) exp_err = 1'b1;
  endtask

  task automatic send_frame(input logic [3:0] a, input logic [7:0] d);
    logic [11:0] f;
    f = {a, d};
    for (int i = 11; i >= 0; i--) send_bit(f[i]);
  endtask

  task automatic pulse_load();
    load = 1'b1;
    wait_clk(6);
    if (addr_valid(exp_sh[11:8])) exp_code[exp_sh[11:8] - 4'd1] = exp_sh[7:0];
    load = 1'b0;
    wait_clk(6);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5EED_0043);
    rst_n = 1'b0; ser_clk = 1'b0; ser_din = 1'b0; load = 1'b0;
    preset_n = 1'b1; err_clr = 1'b0;
    for (int c = 0; c < NCH; c++) exp_code[c] = 8'h80;
    exp_sh = '0; exp_err = 1'b0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    check_all("R12 reset");

    // R2 R3: directed frame per channel, loaded in reverse order
    for (int c = 7; c >= 0; c--) begin
      send_frame(4'(c + 1), 8'(8'h11 * (c + 1)));
      pulse_load();
    end
    check_all("R3 R2 R5 address map");

    // R4: no-op addresses at both ends of the range
    send_frame(4'h0, 8'h5A); pulse_load(); check_all("R4 addr 0");
    send_frame(4'h9, 8'hA5); pulse_load(); check_all("R4 addr 9");
    send_frame(4'hF, 8'h3C); pulse_load(); check_all("R4 addr 15");

    // R11: a second load of the same frame keeps shift contents and code
    send_frame(4'h2, 8'hE7); pulse_load(); pulse_load();
    check_all("R11 retain after load");

    // R1 R6: partial frame, check the output bit by bit
    for (int i = 0; i < 14; i++) begin
      send_bit(1'(i % 3 == 0));
      chk("R1 R6 dout", 32'(ser_dout), 32'(exp_sh[11]));
    end

    // Random frames
    for (int n = 0; n < 60; n++) begin
      logic [3:0] a;
      logic [7:0] d;
      a = 4'($urandom_range(0, 15));
      d = 8'($urandom);
      send_frame(a, d);
      if ($urandom_range(0, 3) != 0) pulse_load();
      check_all(addr_valid(a) ? "R5 random load" : "R4 random noop");
    end

    // R7: preset, with serial and load activity ignored
    preset_n = 1'b0;
    wait_clk(6);
    for (int c = 0; c < NCH; c++) exp_code[c] = 8'h80;
    exp_sh = '0;
    check_all("R7 preset");
    ser_din = 1'b1; ser_clk = 1'b1; wait_clk(4); ser_clk = 1'b0; wait_clk(4);
    load = 1'b1; wait_clk(4); load = 1'b0; wait_clk(4);
    check_all("R7 ignored during preset");

    // R8: load held high across preset release
    send_frame(4'h3, 8'h77);
    preset_n = 1'b0; wait_clk(6);
    load = 1'b1; wait_clk(4);
    preset_n = 1'b1; wait_clk(8);
    load = 1'b0; wait_clk(6);
    for (int c = 0; c < NCH; c++) exp_code[c] = 8'h80;
    exp_sh = '0;
    check_all("R8 preset release with load");

    // R9: serial edge while load high; capture happens first
    send_frame(4'h4, 8'hC3);
    load = 1'b1; wait_clk(6);
    exp_code[3] = 8'hC3;
    send_bit(1'b0);
    load = 1'b0; wait_clk(6);
    check_all("R9 violation");
    send_frame(4'h0, 8'h00);
    check_all("R10 sticky");

    // R10: clear
    err_clr = 1'b1; wait_clk(1); err_clr = 1'b0; wait_clk(2);
    exp_err = 1'b0;
    check_all("R10 clear");

    // R12: reset mid-operation
    send_frame(4'h8, 8'h01); pulse_load();
    rst_n = 1'b0; wait_clk(3); rst_n = 1'b1; wait_clk(4);
    for (int c = 0; c < NCH; c++) exp_code[c] = 8'h80;
    exp_sh = '0; exp_err = 1'b0;
    check_all("R12 reset again");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule